// File: doc/BRIEF.md
# Parallel NOR Flash Read Data Multiplexer

This block is the read path of a parallel NOR flash model. A read request carries a byte address, an access size of 1, 2 or 4 bytes and an endianness flag. Depending on the command state supplied by the neighbouring command sequencer, the block returns one of four things: bytes assembled from the external array, a manufacturer or device identifier word, the current status byte, or one byte of the common flash query table. The query table is computed from the chip geometry parameters.

The block also owns the direct-array-read mode flag. The first write of any command sequence clears this flag. Once the flag is clear and the sequencer is idle, the block counts reads and sets the flag again after a fixed number of them. A read taken in a command state the block does not recognise is served from the array, and the block sends a one-cycle request to the sequencer to fall back to its read state.

Requests use a valid/ready handshake, and so do responses. The block holds a single response register. A request is accepted when `req_ready` is high, which happens whenever the response register is empty or is being drained in the same cycle. When `rsp_ready` is low, a pending response holds `rsp_data` unchanged and the block accepts no new request.

Top module: `flash_rd_mux`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at a clock edge appears on `rsp_valid`/`rsp_data` right after that edge. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` stays unchanged.
- R2: Array reads in command state 0 take `req_size` 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes. `arr_rdata` lane k (bits 8k+7:8k) holds the byte at address `arr_addr`+k, and `arr_addr` equals `req_addr`. With `req_be` low, the byte at the lowest address lands in bits 7:0. With `req_be` high, it lands in the most significant byte of the access. Unused upper bits are zero.
- R3: The identifier/query word offset is `req_addr[7:0]` shifted right by log2(DEV_BYTES). Both byte addresses of one 16-bit word therefore give the same result.
- R4: In autoselect state (2), offset 0 returns ID0, offset 1 returns ID1 and offset 2 returns 0. Each is zero-extended to 32 bits.
- R5: In autoselect state, offset 0x0E returns ID2 and offset 0x0F returns ID3. If that identifier's low byte is 0xFF, the read returns array data instead. Every other offset returns array data.
- R6: In status state (3), the response is `status_byte` zero-extended.
- R7: In query state (4), the table gives "QRY" at offsets 0x10-0x12, 0x02 at 0x13, 0x31 at 0x15, and "PRI" then "10" at 0x31-0x35 (ASCII).
- R8: In query state, offset 0x27 returns ADDR_W, the log2 of the chip size, and 0x2C returns 1. Offsets 0x2D/0x2E return the sector count minus one (low/high byte). Offsets 0x2F/0x30 return the sector size divided by 256 (low/high byte).
- R9: In query state, offsets at or above 0x52 and offsets with no listed entry return 0.
- R10: `direct_mode` is 1 after reset. When it is 0, every accepted read with `cmd_idle` high increments a count, and `direct_mode` returns to 1 at the edge that takes the count above LAZY_LIMIT (42). Reads accepted while `cmd_idle` is low are not counted.
- R11: A `cmd_first_wr` pulse clears the count and `direct_mode` at the next edge.
- R12: In erase-setup state (1), reads return array data exactly as in state 0.
- R13: States 5-7 return array data. `seq_abort` is high for exactly the one cycle in which that response first appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Byte address of the read |
| req_size | input | 2 | Access size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| req_be | input | 1 | Big-endian byte order for array reads |
| cmd_state | input | 3 | Sequencer state: 0 array, 1 erase setup, 2 autoselect, 3 status, 4 query |
| status_byte | input | 8 | Current status byte |
| cmd_idle | input | 1 | No command cycle pending |
| cmd_first_wr | input | 1 | First write of a command sequence |
| arr_addr | output | ADDR_W | Array base byte address |
| arr_rdata | input | 32 | Array bytes at arr_addr+0..3, one per lane |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 32 | Read data, zero-extended |
| seq_abort | output | 1 | Request to return the sequencer to read state |
| direct_mode | output | 1 | Direct array-read mode flag |

## Verification
The response to a request accepted at edge N is due right after edge N. The bench therefore drives the request on a falling edge and samples `rsp_data` on the following falling edge, half a cycle after the capturing edge. `seq_abort` is sampled in the same cycle as its response and again one cycle later, where it must be low. A `direct_mode` change caused by a read or a `cmd_first_wr` pulse is due at that same edge and is sampled on the next falling edge. Under back-pressure, the bench samples across two stalled edges before it releases `rsp_ready`.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [2:0] {
    ST_ARRAY       = 3'd0,
    ST_ERASE_SETUP = 3'd1,
    ST_AUTOSEL     = 3'd2,
    ST_STATUS      = 3'd3,
    ST_QUERY       = 3'd4
  } cmd_state_e;

  localparam logic [7:0] QUERY_LEN = 8'h52;

  function automatic int unsigned size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/fr_byte_pack.sv
module fr_byte_pack (
  input  logic [31:0] lanes,
  input  logic [1:0]  size_code,
  input  logic        big_end,
  output logic [31:0] word
);
  import flash_rd_pkg::*;

  logic [7:0] b [4];

  generate
    for (genvar k = 0; k < 4; k++) begin : g_lane
      assign b[k] = lanes[8*k +: 8];
    end
  endgenerate

  always_comb begin
    word = '0;
    case (size_to_bytes(size_code))
      1: word = {24'b0, b[0]};
      2: word = big_end ? {16'b0, b[0], b[1]} : {16'b0, b[1], b[0]};
      default: word = big_end ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
    endcase
  end
endmodule

// File: rtl/fr_query_rom.sv
module fr_query_rom #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SECTOR_BYTES = 4096
) (
  input  logic [7:0] offset,
  output logic [7:0] qbyte
);
  import flash_rd_pkg::*;

  localparam int unsigned CHIP_BYTES = 32'd1 << ADDR_W;
  localparam int unsigned NSEC_M1    = CHIP_BYTES / SECTOR_BYTES - 1;
  localparam logic [7:0]  SZ_LOG     = 8'(ADDR_W);
  localparam logic [7:0]  NSEC_LO    = 8'(NSEC_M1 & 32'hFF);
  localparam logic [7:0]  NSEC_HI    = 8'((NSEC_M1 >> 8) & 32'hFF);
  localparam logic [7:0]  SEC_LO     = 8'((SECTOR_BYTES >> 8) & 32'hFF);
  localparam logic [7:0]  SEC_HI     = 8'((SECTOR_BYTES >> 16) & 32'hFF);

  logic [7:0] entry;

  always_comb begin
    case (offset)
      8'h10: entry = 8'h51;
      8'h11: entry = 8'h52;
      8'h12: entry = 8'h59;
      8'h13: entry = 8'h02;
      8'h15: entry = 8'h31;
      8'h1B: entry = 8'h27;
      8'h1C: entry = 8'h36;
      8'h1F: entry = 8'h07;
      8'h21: entry = 8'h09;
      8'h22: entry = 8'h0C;
      8'h23: entry = 8'h01;
      8'h25: entry = 8'h0A;
      8'h26: entry = 8'h0D;
      8'h27: entry = SZ_LOG;
      8'h28: entry = 8'h02;
      8'h2C: entry = 8'h01;
      8'h2D: entry = NSEC_LO;
      8'h2E: entry = NSEC_HI;
      8'h2F: entry = SEC_LO;
      8'h30: entry = SEC_HI;
      8'h31: entry = 8'h50;
      8'h32: entry = 8'h52;
      8'h33: entry = 8'h49;
      8'h34: entry = 8'h31;
      8'h35: entry = 8'h30;
      default: entry = 8'h00;
    endcase
    qbyte = (offset >= QUERY_LEN) ? 8'h00 : entry;
  end
endmodule

// File: rtl/fr_ident_sel.sv
module fr_ident_sel #(
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h22A5,
  parameter logic [15:0] ID2 = 16'h00FF,
  parameter logic [15:0] ID3 = 16'h2201
) (
  input  logic [7:0]  offset,
  output logic        hit,
  output logic [15:0] value
);
  always_comb begin
    hit   = 1'b0;
    value = '0;
    case (offset)
      8'h00: begin hit = 1'b1; value = ID0; end
      8'h01: begin hit = 1'b1; value = ID1; end
      8'h02: begin hit = 1'b1; value = 16'h0000; end
      8'h0E: begin hit = (ID2[7:0] != 8'hFF); value = ID2; end
      8'h0F: begin hit = (ID3[7:0] != 8'hFF); value = ID3; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fr_lazy_ctrl.sv
module fr_lazy_ctrl #(
  parameter int unsigned LIMIT = 42
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_fire,
  input  logic idle,
  input  logic first_wr,
  output logic direct
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      direct <= 1'b1;
    end else if (first_wr) begin
      cnt    <= '0;
      direct <= 1'b0;
    end else if (rd_fire && idle && !direct) begin
      if (cnt != {CNT_W{1'b1}}) cnt <= cnt_inc[CNT_W-1:0];
      if (cnt_inc > (CNT_W+1)'(LIMIT)) direct <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DEV_BYTES    = 2,
  parameter int unsigned SECTOR_BYTES = 4096,
  parameter int unsigned LAZY_LIMIT   = 42,
  parameter logic [15:0] ID0          = 16'h0001,
  parameter logic [15:0] ID1          = 16'h22A5,
  parameter logic [15:0] ID2          = 16'h00FF,
  parameter logic [15:0] ID3          = 16'h2201
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_be,
  input  logic [2:0]        cmd_state,
  input  logic [7:0]        status_byte,
  input  logic              cmd_idle,
  input  logic              cmd_first_wr,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [31:0]       arr_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              seq_abort,
  output logic              direct_mode
);
  import flash_rd_pkg::*;

  localparam int unsigned OFF_SHIFT = (DEV_BYTES >= 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;

  cmd_state_e  st;
  logic        accept;
  logic [7:0]  word_off;
  logic [31:0] arr_word;
  logic        id_hit;
  logic [15:0] id_val;
  logic [7:0]  q_byte;
  logic [31:0] rd_word;
  logic        unknown_st;

  assign st        = cmd_state_e'(cmd_state);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign arr_addr  = req_addr;
  assign word_off  = req_addr[7:0] >> OFF_SHIFT;

  fr_byte_pack u_pack (
    .lanes     (arr_rdata),
    .size_code (req_size),
    .big_end   (req_be),
    .word      (arr_word)
  );

  fr_ident_sel #(.ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_ident (
    .offset (word_off),
    .hit    (id_hit),
    .value  (id_val)
  );

  fr_query_rom #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_query (
    .offset (word_off),
    .qbyte  (q_byte)
  );

  fr_lazy_ctrl #(.LIMIT(LAZY_LIMIT)) u_lazy (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (accept),
    .idle     (cmd_idle),
    .first_wr (cmd_first_wr),
    .direct   (direct_mode)
  );

  always_comb begin
    unknown_st = 1'b0;
    rd_word    = arr_word;
    case (st)
      ST_ARRAY, ST_ERASE_SETUP: rd_word = arr_word;
      ST_AUTOSEL:               if (id_hit) rd_word = {16'b0, id_val};
      ST_STATUS:                rd_word = {24'b0, status_byte};
      ST_QUERY:                 rd_word = {24'b0, q_byte};
      default:                  unknown_st = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      seq_abort <= 1'b0;
    end else begin
      seq_abort <= accept && unknown_st;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_word;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_rd_mux_chk.sv
module flash_rd_mux_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              req_be,
  input logic [2:0]        cmd_state,
  input logic [7:0]        status_byte,
  input logic              cmd_idle,
  input logic              cmd_first_wr,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [31:0]       arr_rdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_data,
  input logic              seq_abort,
  input logic              direct_mode
);
  logic past_ok;
  logic acc;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R1
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R2
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(acc && cmd_state == 3'd0 && req_size == 2'd0) |-> rsp_data[31:8] == 24'b0);

  // R6
  status_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(acc && cmd_state == 3'd3) |-> rsp_data == {24'b0, $past(status_byte)});

  // R10
  direct_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(direct_mode) |-> $past(acc && cmd_idle));

  // R11
  first_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_first_wr |=> !direct_mode);

  // R13
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |-> rsp_valid && past_ok && $past(acc && cmd_state >= 3'd5));
endmodule

bind flash_rd_mux flash_rd_mux_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_rd_mux_tb.sv
module flash_rd_mux_tb;
  localparam int unsigned AW = 16;
  localparam logic [15:0] T_ID0 = 16'h0001;
  localparam logic [15:0] T_ID1 = 16'h22A5;
  localparam logic [15:0] T_ID2 = 16'h00FF;
  localparam logic [15:0] T_ID3 = 16'h2201;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_be = 1'b0;
  logic [2:0]    cmd_state = '0;
  logic [7:0]    status_byte = '0;
  logic          cmd_idle = 1'b1;
  logic          cmd_first_wr = 1'b0;
  logic [AW-1:0] arr_addr;
  logic [31:0]   arr_rdata;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_data;
  logic          seq_abort;
  logic          direct_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_rd_mux #(.ADDR_W(AW), .DEV_BYTES(2), .SECTOR_BYTES(4096), .LAZY_LIMIT(42),
                 .ID0(T_ID0), .ID1(T_ID1), .ID2(T_ID2), .ID3(T_ID3)) u_dut (.*);

  function automatic logic [7:0] mem_b(input int a);
    int m;
    m = a & 32'hFFFF;
    return 8'((m * 13 + (m >> 8) + 60) & 32'hFF);
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++) arr_rdata[8*k +: 8] = mem_b(int'(arr_addr) + k);
  end

  function automatic logic [31:0] exp_arr(input int a, input int sz, input bit be);
    int n;
    logic [31:0] v;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    v = '0;
    for (int i = 0; i < n; i++) begin
      if (be) v = v | (32'(mem_b(a + i)) << (8 * (n - 1 - i)));
      else    v = v | (32'(mem_b(a + i)) << (8 * i));
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_query(input int off);
    case (off)
      16'h10: return 8'h51;  16'h11: return 8'h52;  16'h12: return 8'h59;
      16'h13: return 8'h02;  16'h15: return 8'h31;  16'h1B: return 8'h27;
      16'h1C: return 8'h36;  16'h1F: return 8'h07;  16'h21: return 8'h09;
      16'h22: return 8'h0C;  16'h23: return 8'h01;  16'h25: return 8'h0A;
      16'h26: return 8'h0D;  16'h27: return 8'd16;  16'h28: return 8'h02;
      16'h2C: return 8'h01;  16'h2D: return 8'd15;  16'h2E: return 8'h00;
      16'h2F: return 8'h10;  16'h30: return 8'h00;  16'h31: return 8'h50;
      16'h32: return 8'h52;  16'h33: return 8'h49;  16'h34: return 8'h31;
      16'h35: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rd(input int a, input int sz, input bit be, input int st, input bit idle);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(a);
    req_size  = 2'(sz);
    req_be    = be;
    cmd_state = 3'(st);
    cmd_idle  = idle;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cmd_idle  = 1'b1;
  endtask

  task automatic first_wr();
    @(negedge clk);
    cmd_first_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_first_wr = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state (R1, R10)
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 reset req_ready", 32'(req_ready), 32'd1);
    chk("R10 reset direct_mode", 32'(direct_mode), 32'd1);
    chk("R13 reset seq_abort", 32'(seq_abort), 32'd0);
    rst_n = 1'b1;

    // R2 array reads: sizes x endian x addresses incl. wrap at top
    for (int a = 0; a < 40; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int be = 0; be < 2; be++) begin
          int addr;
          addr = (a < 36) ? a * 37 : 16'hFFFC + (a - 36);
          rd(addr, sz, 1'(be), 0, 1'b1);
          chk("R2 array read", rsp_data, exp_arr(addr, sz, 1'(be)));
          chk("R1 rsp_valid after accept", 32'(rsp_valid), 32'd1);
        end
      end
    end

    // R12 erase setup serves the array
    for (int a = 0; a < 16; a++) begin
      rd(a * 301, a % 3, 1'(a % 2), 1, 1'b1);
      chk("R12 erase-setup array read", rsp_data, exp_arr(a * 301, a % 3, 1'(a % 2)));
    end

    // R3/R4/R5 autoselect sweep, both byte addresses of each word
    for (int off = 0; off < 128; off++) begin
      for (int lo = 0; lo < 2; lo++) begin
        int addr;
        logic [31:0] e;
        addr = 16'h0500 + off * 2 + lo;
        if (off == 0)       e = {16'b0, T_ID0};
        else if (off == 1)  e = {16'b0, T_ID1};
        else if (off == 2)  e = 32'd0;
        else if (off == 15) e = {16'b0, T_ID3};
        else                e = exp_arr(addr, 1, 1'b0);
        rd(addr, 1, 1'b0, 2, 1'b1);
        if (off < 3)        chk("R4 autoselect id/protect", rsp_data, e);
        else if (off == 14) chk("R5 id2 fallback to array", rsp_data, e);
        else if (off == 15) chk("R5 id3 word", rsp_data, e);
        else                chk("R3 R5 other offset array", rsp_data, e);
      end
    end

    // R6 status
    for (int s = 0; s < 8; s++) begin
      status_byte = 8'(s * 37 + 128);
      rd(s, 2, 1'b1, 3, 1'b1);
      chk("R6 status byte", rsp_data, {24'b0, 8'(s * 37 + 128)});
    end

    // R7/R8/R9 query table sweep (word offsets 0..127)
    for (int off = 0; off < 128; off++) begin
      rd(off * 2 + 1, 0, 1'b0, 4, 1'b1);
      if (off >= 16'h52)                    chk("R9 query beyond length", rsp_data, 32'd0);
      else if (off >= 16'h27 && off <= 16'h30) chk("R8 query geometry", rsp_data, {24'b0, exp_query(off)});
      else                                   chk("R7 R9 query entry", rsp_data, {24'b0, exp_query(off)});
    end

    // R13 unknown states
    for (int st = 5; st < 8; st++) begin
      rd(st * 111, 2, 1'b0, st, 1'b1);
      chk("R13 unknown state array", rsp_data, exp_arr(st * 111, 2, 1'b0));
      chk("R13 seq_abort pulse", 32'(seq_abort), 32'd1);
      @(negedge clk);
      chk("R13 seq_abort single cycle", 32'(seq_abort), 32'd0);
    end

    // R1 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 16'h0100; req_size = 2'd1; req_be = 1'b0; cmd_state = 3'd0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 first response", rsp_data, exp_arr(16'h0100, 1, 1'b0));
    chk("R1 req_ready low when stalled", 32'(req_ready), 32'd0);
    req_addr = 16'h0200;
    @(posedge clk);
    @(negedge clk);
    chk("R1 data held under stall", rsp_data, exp_arr(16'h0100, 1, 1'b0));
    chk("R1 valid held under stall", 32'(rsp_valid), 32'd1);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 next response after release", rsp_data, exp_arr(16'h0200, 1, 1'b0));
    @(posedge clk);
    @(negedge clk);
    chk("R1 valid drops when drained", 32'(rsp_valid), 32'd0);

    // R10/R11 lazy return
    first_wr();
    chk("R11 first write clears direct_mode", 32'(direct_mode), 32'd0);
    for (int i = 0; i < 42; i++) rd(i, 0, 1'b0, 0, 1'b1);
    chk("R10 still off after 42 reads", 32'(direct_mode), 32'd0);
    rd(0, 0, 1'b0, 0, 1'b0);
    chk("R10 busy read not counted", 32'(direct_mode), 32'd0);
    rd(0, 0, 1'b0, 0, 1'b1);
    chk("R10 on after 43rd counted read", 32'(direct_mode), 32'd1);
    first_wr();
    chk("R11 cleared again", 32'(direct_mode), 32'd0);
    for (int i = 0; i < 42; i++) rd(i, 0, 1'b0, 2, 1'b1);
    chk("R11 count restarted", 32'(direct_mode), 32'd0);
    rd(0, 0, 1'b0, 3, 1'b1);
    chk("R10 counts in any state", 32'(direct_mode), 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule